// File: doc/BRIEF.md
# Converter Reset Sequencer

This block sits in the master-clock domain of an audio converter and turns the software run/reset control bit into the timed internal signals the converter datapaths need. It derives a sample tick from the frame clock, then schedules the fall and rise of an internal active-low reset, a zero-detect flag and a converter initialisation window, all counted in whole sample ticks. It does not touch any control register other than by observing the run bit, so register contents survive the reset.

While the internal reset is asserted, both serial data outputs are held low and the ADC sample path is forced to zero. After the internal reset is released, the ADC sample path stays at zero for a fixed initialisation window, and a busy output marks that window. An asynchronous power-down input forces every counter and output into the reset state at once. Ticks stop when the frame clock stops, and the sequencer stops with them.

Top module: `conv_rst_seq`

## Requirements
- R1: A rising edge of `frameClk` that is set up before clock edge e is counted as one sample tick at edge e+2. When `frameClk` stops toggling, no tick is counted and no scheduled change of `intRstN`, `zeroFlag` or `adcBusy` takes place.
- R2: `rstBit` is 1 for run and 0 for reset. When a clock edge samples `rstBit` going from 1 to 0, `intRstN` (active low) falls at the edge of the 5th sample tick counted after that edge, which gives a delay of 4 to 5 sample periods.
- R3: When a clock edge samples `rstBit` going from 0 to 1 while `intRstN` is low, `intRstN` rises at the edge of the 2nd sample tick counted after that edge, which gives a delay of 1 to 2 sample periods.
- R4: `zeroFlag` is set at the edge that samples `rstBit` going to 0, so it reads high from the next cycle. It clears at the edge of the 7th sample tick counted after the edge that samples `rstBit` going to 1.
- R5: Each change of `rstBit` restarts the sequence count. If `rstBit` returns to 1 before the assertion delay ends, the pending assertion is dropped: `intRstN` stays high and no initialisation window starts.
- R6: `adcBusy` rises at the same edge as `intRstN` and clears at the edge of the 516th sample tick counted after that edge. It also clears at once if `intRstN` falls first.
- R7: `adcSampleOut` is all zeros while `intRstN` is low or `adcBusy` is high. Otherwise it equals `adcSampleIn` in the same cycle.
- R8: `sdoAOut` and `sdoBOut` are low while `intRstN` is low. Otherwise they follow `sdoAIn` and `sdoBIn`.
- R9: While `pdnN` is low, `intRstN` is 0, `zeroFlag` is 1, `adcBusy` is 0 and all sequence state is cleared, with immediate effect. The sampled run bit is taken as 0, so a high `rstBit` after `pdnN` rises starts a release sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| pdnN | input | 1 | Asynchronous power-down, active low |
| frameClk | input | 1 | Frame clock, asynchronous to clk |
| rstBit | input | 1 | Run/reset control bit from the register file (1 = run) |
| adcSampleIn | input | DATA_W | ADC sample from the converter datapath |
| sdoAIn | input | 1 | Serial data for port A |
| sdoBIn | input | 1 | Serial data for port B |
| intRstN | output | 1 | Internal datapath reset, active low |
| zeroFlag | output | 1 | Zero-detect flag |
| adcBusy | output | 1 | ADC initialisation window in progress |
| adcSampleOut | output | DATA_W | Masked ADC sample |
| sdoAOut | output | 1 | Masked serial data, port A |
| sdoBOut | output | 1 | Masked serial data, port B |

## Verification
A frame-clock rise is seen as a tick two edges later. Every scheduled change of `intRstN`, `zeroFlag` and `adcBusy` then lands on the edge of the Nth counted tick, where N is 5, 2, 7 or 516, and reads back from the next cycle. The masked outputs follow their inputs in the same cycle. The bench runs a behavioural model of these rules on the same clock edges as the design and compares every output at the falling edge, half a cycle after any change, so each result is checked on the cycle it is due and not merely within a window.

// File: rtl/conv_rst_seq_pkg.sv
package conv_rst_seq_pkg;

  // Sequence phase: which schedule the sequence counter is timing.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ASSERT  = 2'd1,
    PH_RELEASE = 2'd2
  } seq_phase_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic seqRestart;
    logic seqStep;
    logic initRestart;
    logic initStep;
  } seq_strb_t;

endpackage

// File: rtl/conv_rst_seq_dp.sv
module conv_rst_seq_dp
  import conv_rst_seq_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int SEQ_W       = 3,
  parameter int INIT_W      = 10
) (
  input  logic              clk,
  input  logic              pdnN,
  input  logic              frameClk,
  input  seq_strb_t         strb,
  input  logic              intRstN,
  input  logic              busy,
  input  logic [DATA_W-1:0] adcSampleIn,
  input  logic              sdoAIn,
  input  logic              sdoBIn,
  output logic              tick,
  output logic [SEQ_W-1:0]  seqCnt,
  output logic [INIT_W-1:0] initCnt,
  output logic [DATA_W-1:0] adcSampleOut,
  output logic              sdoAOut,
  output logic              sdoBOut
);

  // Frame clock synchroniser chain
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge pdnN) begin
          if (!pdnN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= frameClk;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge pdnN) begin
          if (!pdnN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign tick = syncQ[SYNC_STAGES-1] & ~prevQ;

  // Sequence counter: ticks since the last run-bit change
  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN)                seqCnt <= '0;
    else if (strb.seqRestart) seqCnt <= '0;
    else if (strb.seqStep)    seqCnt <= seqCnt + 1'b1;
  end

  // Initialisation window counter
  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN)                 initCnt <= '0;
    else if (strb.initRestart) initCnt <= '0;
    else if (strb.initStep)    initCnt <= initCnt + 1'b1;
  end

  // Output masking
  logic adcPass;
  assign adcPass      = intRstN & ~busy;
  assign adcSampleOut = adcPass ? adcSampleIn : '0;
  assign sdoAOut      = intRstN & sdoAIn;
  assign sdoBOut      = intRstN & sdoBIn;

endmodule

// File: rtl/conv_rst_seq_ctrl.sv
module conv_rst_seq_ctrl
  import conv_rst_seq_pkg::*;
#(
  parameter int SEQ_W        = 3,
  parameter int INIT_W       = 10,
  parameter int ASSERT_TICKS = 5,
  parameter int RELEASE_TICKS = 2,
  parameter int FLAG_TICKS   = 7,
  parameter int INIT_TICKS   = 516
) (
  input  logic              clk,
  input  logic              pdnN,
  input  logic              rstBit,
  input  logic              tick,
  input  logic [SEQ_W-1:0]  seqCnt,
  input  logic [INIT_W-1:0] initCnt,
  output seq_strb_t         strb,
  output logic              intRstN,
  output logic              zeroFlag,
  output logic              busy
);

  localparam logic [SEQ_W-1:0]  ASSERT_LAST = SEQ_W'(ASSERT_TICKS - 1);
  localparam logic [SEQ_W-1:0]  REL_LAST    = SEQ_W'(RELEASE_TICKS - 1);
  localparam logic [SEQ_W-1:0]  FLAG_LAST   = SEQ_W'(FLAG_TICKS - 1);
  localparam logic [INIT_W-1:0] INIT_LAST   = INIT_W'(INIT_TICKS - 1);

  seq_phase_e phase;
  logic       rstBitQ;
  logic       chg;
  logic       seqStep;
  logic       initStep;
  logic       assertHit;
  logic       relHit;
  logic       flagHit;
  logic       initDone;

  assign chg       = rstBit ^ rstBitQ;
  assign seqStep   = tick && (phase != PH_IDLE) && !chg;
  assign assertHit = seqStep && (phase == PH_ASSERT) && (seqCnt == ASSERT_LAST);
  assign relHit    = seqStep && (phase == PH_RELEASE) && (seqCnt == REL_LAST) && !intRstN;
  assign flagHit   = seqStep && (phase == PH_RELEASE) && (seqCnt == FLAG_LAST);
  assign initStep  = tick && busy;
  assign initDone  = initStep && (initCnt == INIT_LAST);

  always_comb begin
    strb.seqRestart  = chg;
    strb.seqStep     = seqStep;
    strb.initRestart = relHit;
    strb.initStep    = initStep;
  end

  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN) begin
      rstBitQ <= 1'b0;
      phase   <= PH_IDLE;
    end else begin
      rstBitQ <= rstBit;
      if (chg)                      phase <= rstBit ? PH_RELEASE : PH_ASSERT;
      else if (assertHit || flagHit) phase <= PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN) begin
      intRstN <= 1'b0;
      busy    <= 1'b0;
    end else if (assertHit) begin
      intRstN <= 1'b0;
      busy    <= 1'b0;
    end else if (relHit) begin
      intRstN <= 1'b1;
      busy    <= 1'b1;
    end else if (initDone) begin
      busy    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge pdnN) begin
    if (!pdnN)                zeroFlag <= 1'b1;
    else if (chg && !rstBit)  zeroFlag <= 1'b1;
    else if (flagHit)         zeroFlag <= 1'b0;
  end

endmodule

// File: rtl/conv_rst_seq.sv
module conv_rst_seq
  import conv_rst_seq_pkg::*;
#(
  parameter int DATA_W          = 24,
  parameter int SYNC_STAGES     = 2,
  parameter int ASSERT_PERIODS  = 4,
  parameter int RELEASE_PERIODS = 1,
  parameter int FLAG_PERIODS    = 6,
  parameter int INIT_PERIODS    = 516
) (
  input  logic              clk,
  input  logic              pdnN,
  input  logic              frameClk,
  input  logic              rstBit,
  input  logic [DATA_W-1:0] adcSampleIn,
  input  logic              sdoAIn,
  input  logic              sdoBIn,
  output logic              intRstN,
  output logic              zeroFlag,
  output logic              adcBusy,
  output logic [DATA_W-1:0] adcSampleOut,
  output logic              sdoAOut,
  output logic              sdoBOut
);

  // One extra tick absorbs the unknown phase of the write against the tick.
  localparam int ASSERT_TICKS  = ASSERT_PERIODS + 1;
  localparam int RELEASE_TICKS = RELEASE_PERIODS + 1;
  localparam int FLAG_TICKS    = FLAG_PERIODS + 1;
  localparam int INIT_TICKS    = INIT_PERIODS;
  localparam int SEQ_MAX       = (FLAG_TICKS > ASSERT_TICKS) ? FLAG_TICKS : ASSERT_TICKS;
  localparam int SEQ_W         = $clog2(SEQ_MAX + 1);
  localparam int INIT_W        = $clog2(INIT_TICKS + 1);

  seq_strb_t         strb;
  logic              tick;
  logic [SEQ_W-1:0]  seqCnt;
  logic [INIT_W-1:0] initCnt;

  conv_rst_seq_ctrl #(
    .SEQ_W        (SEQ_W),
    .INIT_W       (INIT_W),
    .ASSERT_TICKS (ASSERT_TICKS),
    .RELEASE_TICKS(RELEASE_TICKS),
    .FLAG_TICKS   (FLAG_TICKS),
    .INIT_TICKS   (INIT_TICKS)
  ) u_ctrl (
    .clk     (clk),
    .pdnN    (pdnN),
    .rstBit  (rstBit),
    .tick    (tick),
    .seqCnt  (seqCnt),
    .initCnt (initCnt),
    .strb    (strb),
    .intRstN (intRstN),
    .zeroFlag(zeroFlag),
    .busy    (adcBusy)
  );

  conv_rst_seq_dp #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES),
    .SEQ_W      (SEQ_W),
    .INIT_W     (INIT_W)
  ) u_dp (
    .clk         (clk),
    .pdnN        (pdnN),
    .frameClk    (frameClk),
    .strb        (strb),
    .intRstN     (intRstN),
    .busy        (adcBusy),
    .adcSampleIn (adcSampleIn),
    .sdoAIn      (sdoAIn),
    .sdoBIn      (sdoBIn),
    .tick        (tick),
    .seqCnt      (seqCnt),
    .initCnt     (initCnt),
    .adcSampleOut(adcSampleOut),
    .sdoAOut     (sdoAOut),
    .sdoBOut     (sdoBOut)
  );

endmodule

// File: rtl/conv_rst_seq_chk.sv
module conv_rst_seq_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              pdnN,
  input logic              rstBit,
  input logic              intRstN,
  input logic              zeroFlag,
  input logic              adcBusy,
  input logic [DATA_W-1:0] adcSampleOut,
  input logic              sdoAOut,
  input logic              sdoBOut
);

  // R8
  sdo_mask_chk: assert property (@(posedge clk) disable iff (!pdnN)
    !intRstN |-> (!sdoAOut && !sdoBOut));

  // R7
  adc_zero_chk: assert property (@(posedge clk) disable iff (!pdnN)
    (!intRstN || adcBusy) |-> (adcSampleOut == '0));

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!pdnN)
    !rstBit |=> zeroFlag);

  // R6
  busy_in_run_chk: assert property (@(posedge clk) disable iff (!pdnN)
    adcBusy |-> intRstN);

  // R3
  release_flag_chk: assert property (@(posedge clk) disable iff (!pdnN)
    $rose(intRstN) |-> zeroFlag);

  // R4
  flag_clear_run_chk: assert property (@(posedge clk) disable iff (!pdnN)
    !zeroFlag |-> intRstN);

  // R9
  pdn_state_chk: assert property (@(posedge clk)
    !pdnN |-> (!intRstN && zeroFlag && !adcBusy));

endmodule

bind conv_rst_seq conv_rst_seq_chk #(.DATA_W(DATA_W)) u_conv_rst_seq_chk (
  .clk         (clk),
  .pdnN        (pdnN),
  .rstBit      (rstBit),
  .intRstN     (intRstN),
  .zeroFlag    (zeroFlag),
  .adcBusy     (adcBusy),
  .adcSampleOut(adcSampleOut),
  .sdoAOut     (sdoAOut),
  .sdoBOut     (sdoBOut)
);

// File: tb/conv_rst_seq_bench.sv
module conv_rst_seq_bench;

  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          pdnN = 1'b1;
  logic          frameClk = 1'b0;
  logic          rstBit = 1'b1;
  logic [DW-1:0] adcSampleIn = '0;
  logic          sdoAIn = 1'b0;
  logic          sdoBIn = 1'b0;
  logic          intRstN, zeroFlag, adcBusy, sdoAOut, sdoBOut;
  logic [DW-1:0] adcSampleOut;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  frameRun = 1;
  int  frameCnt = 0;
  int  seed = 32'h5eed1234;

  always #5 clk = ~clk;

  conv_rst_seq #(.DATA_W(DW)) u_conv_rst_seq (
    .clk(clk), .pdnN(pdnN), .frameClk(frameClk), .rstBit(rstBit),
    .adcSampleIn(adcSampleIn), .sdoAIn(sdoAIn), .sdoBIn(sdoBIn),
    .intRstN(intRstN), .zeroFlag(zeroFlag), .adcBusy(adcBusy),
    .adcSampleOut(adcSampleOut), .sdoAOut(sdoAOut), .sdoBOut(sdoBOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of the requirements
  logic [2:0] fs;
  logic       mRstQ;
  int         mPhase;   // 0 idle, 1 assert pending, 2 release pending
  int         mCnt;
  int         mInit;
  logic       eRstN, eFlag, eBusy;
  wire        mTick = fs[1] & ~fs[2];   // R1: seen at edge e+2

  always @(posedge clk or negedge pdnN) begin
    if (!pdnN) begin
      fs <= '0; mRstQ <= 1'b0; mPhase <= 0; mCnt <= 0; mInit <= 0;
      eRstN <= 1'b0; eFlag <= 1'b1; eBusy <= 1'b0;   // R9
    end else begin
      fs    <= {fs[1:0], frameClk};
      mRstQ <= rstBit;
      if (rstBit != mRstQ) begin                     // R5 restart
        mPhase <= rstBit ? 2 : 1;
        mCnt   <= 0;
        if (!rstBit) eFlag <= 1'b1;                  // R4
      end else if (mTick && mPhase != 0) begin
        mCnt <= mCnt + 1;
        if (mPhase == 1 && mCnt + 1 == 5) begin      // R2
          eRstN <= 1'b0; eBusy <= 1'b0; mPhase <= 0;
        end
        if (mPhase == 2 && mCnt + 1 == 2 && !eRstN) begin  // R3
          eRstN <= 1'b1; eBusy <= 1'b1; mInit <= 0;
        end
        if (mPhase == 2 && mCnt + 1 == 7) begin      // R4
          eFlag <= 1'b0; mPhase <= 0;
        end
      end
      if (mTick && eBusy) begin                      // R6
        mInit <= mInit + 1;
        if (mInit + 1 == 516) eBusy <= 1'b0;
      end
    end
  end

  // Compare at the falling edge, then move data inputs and frame clock
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 R3 intRstN", intRstN, eRstN);
      chk("R4 zeroFlag", zeroFlag, eFlag);
      chk("R6 adcBusy", adcBusy, eBusy);
      chk("R7 adcSampleOut", adcSampleOut, (eRstN && !eBusy) ? adcSampleIn : '0);
      chk("R8 sdo", {sdoAOut, sdoBOut}, {eRstN & sdoAIn, eRstN & sdoBIn});
    end
    adcSampleIn <= DW'($urandom());
    sdoAIn      <= 1'($urandom());
    sdoBIn      <= 1'($urandom());
    if (frameRun) begin
      if (frameCnt == 3) begin frameClk <= ~frameClk; frameCnt <= 0; end
      else frameCnt <= frameCnt + 1;
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic probe;
    @(negedge clk); #1;
  endtask

  initial begin
    void'($urandom(seed));
    #1 pdnN = 1'b0;
    waitCyc(6);
    probe();
    chk("R9 intRstN", intRstN, 1'b0);
    chk("R9 zeroFlag", zeroFlag, 1'b1);
    chk("R9 adcBusy", adcBusy, 1'b0);
    chk("R8 sdo in power-down", {sdoAOut, sdoBOut}, 2'b00);
    waitCyc(1); pdnN = 1'b1;
    waitCyc(48); probe();
    chk("R3 released", intRstN, 1'b1);
    chk("R6 busy after release", adcBusy, 1'b1);
    chk("R7 zero during init", adcSampleOut, '0);
    waitCyc(4300); probe();
    chk("R6 init done", adcBusy, 1'b0);
    chk("R4 flag cleared", zeroFlag, 1'b0);
    // R1: frame clock stopped, nothing advances
    waitCyc(1); frameRun = 0; rstBit = 1'b0;
    waitCyc(3); probe();
    chk("R4 flag immediate", zeroFlag, 1'b1);
    waitCyc(300); probe();
    chk("R1 no ticks no assert", intRstN, 1'b1);
    waitCyc(1); frameRun = 1;
    waitCyc(80); probe();
    chk("R2 asserted", intRstN, 1'b0);
    chk("R8 sdo low", {sdoAOut, sdoBOut}, 2'b00);
    waitCyc(1); rstBit = 1'b1;
    waitCyc(4400); probe();
    chk("R6 idle before cancel", adcBusy, 1'b0);
    // R5: cancel pending assertion
    waitCyc(1); rstBit = 1'b0;
    waitCyc(16); rstBit = 1'b1;
    waitCyc(80); probe();
    chk("R5 cancel keeps run", intRstN, 1'b1);
    chk("R5 no init window", adcBusy, 1'b0);
    chk("R4 flag after cancel", zeroFlag, 1'b0);
    // Random phase
    for (int it = 0; it < 70; it++) begin
      int sel = int'($urandom_range(0, 9));
      waitCyc(1);
      if (sel < 6)       rstBit = ~rstBit;
      else if (sel == 6) begin pdnN = 1'b0; waitCyc(int'($urandom_range(1, 20))); pdnN = 1'b1; end
      else if (sel == 7) begin frameRun = 0; waitCyc(int'($urandom_range(5, 150))); frameRun = 1; end
      else if (sel == 8) waitCyc(4300);
      waitCyc(int'($urandom_range(3, 160)));
    end
    waitCyc(10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule